// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block is the digital side of an on-chip analog comparator. The comparator's raw output is asynchronous to the system clock, so the block first passes it through a synchronizer chain. It then watches the synchronized level for a selectable kind of change and records each qualifying change in a sticky event flag. An interrupt request is raised while the flag, a local enable and the core's global interrupt enable are all high.

Software reaches the block through one 8-bit control/status word, written with a write strobe and read back at all times. The flag is cleared in two ways: software writes a one to it, or the interrupt controller pulses an acknowledge when the handler is entered. A separate routing bit connects the synchronized comparator level to a timer's capture front end. When that bit is low, the capture line stays low.

The edge detector remembers both the previous level and the previous mode. Because of this, a mode write can itself look like a qualifying event. Software must therefore disable the interrupt before it changes the mode.

Top module: `cmp_event_ctrl`

## Requirements
- R1: The synchronized comparator level is readable at status bit 5. With the default two synchronizer stages, a change on `cmp_raw_i` applied between clock edges appears there after exactly two rising edges.
- R2: Mode code 2'b00 (word bits 1:0) sets the flag (word bit 4) on any change of the synchronized level, in either direction.
- R3: Mode code 2'b10 sets the flag only on a high-to-low change of the synchronized level.
- R4: Mode code 2'b11 sets the flag only on a low-to-high change of the synchronized level.
- R5: Mode code 2'b01 is reserved and never sets the flag.
- R6: A register write with data bit 4 high clears the flag. A write with data bit 4 low leaves the flag unchanged.
- R7: A one-cycle pulse on `irq_ack_i` clears the flag.
- R8: If a detected event and a clear (write-one or acknowledge) land in the same cycle, the flag ends up set.
- R9: `irq_o` is high exactly while the flag, the interrupt enable (word bit 3) and `glob_ie_i` are all high.
- R10: While the capture-routing bit (word bit 2) is high, `cap_trig_o` follows the synchronized level. While it is low, `cap_trig_o` is held low.
- R11: After synchronous active-low reset, word bits 4:0 read zero, and `irq_o` and `cap_trig_o` are low.
- R12: A mode write can set the flag with no comparator activity. Switching from 2'b00 to 2'b11 while the level is high sets it, and so does switching from 2'b11 to 2'b10 while the level is low.
- R13: Word bits 7:6 always read zero. Bit 5 is read-only, so writes do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw_i | input | 1 | Raw asynchronous comparator output |
| glob_ie_i | input | 1 | Global interrupt enable from the core |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse, clears the flag |
| reg_we_i | input | 1 | Control/status word write strobe |
| reg_wdata_i | input | 8 | Control/status word write data |
| reg_rdata_o | output | 8 | Control/status word read data |
| irq_o | output | 1 | Interrupt request |
| cap_trig_o | output | 1 | Comparator level routed to timer capture |

## Verification
The bench builds the block with its defaults: two synchronizer stages and an 8-bit word. This fixes the latency from a raw change to the status bit at two edges, so the bench can check that latency edge by edge. It also lets the bench place a register write in exactly the cycle in which a detected edge reaches the flag logic, which exercises the set-over-clear collision. The short pipeline also makes the mode-change hazard observable within a few cycles of the write that causes it.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_RESV   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } cmp_mode_e;

  localparam int BIT_LVL  = 5;
  localparam int BIT_FLAG = 4;
  localparam int BIT_IE   = 3;
  localparam int BIT_CAP  = 2;

  // Level that counts as "armed" for an edge mode; toggle/reserved never arm.
  function automatic logic armed_level(cmp_mode_e m, logic lvl);
    case (m)
      MODE_RISE: armed_level = lvl;
      MODE_FALL: armed_level = ~lvl;
      default:   armed_level = 1'b0;
    endcase
  endfunction

  // Event decision from current and previous (mode, level) pairs.
  function automatic logic event_hit(cmp_mode_e m, cmp_mode_e pm,
                                     logic lvl, logic plvl);
    case (m)
      MODE_TOGGLE: event_hit = lvl ^ plvl;
      MODE_RESV:   event_hit = 1'b0;
      default:     event_hit = armed_level(m, lvl) & ~armed_level(pm, plvl);
    endcase
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) chain_q[0] <= async_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) chain_q[s] <= chain_q[s-1];
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level_i,
  input  cmp_mode_e mode_i,
  output logic      hit_o
);
  logic      prev_lvl_q;
  cmp_mode_e prev_mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lvl_q  <= level_i;
      prev_mode_q <= MODE_TOGGLE;
    end else begin
      prev_lvl_q  <= level_i;
      prev_mode_q <= mode_i;
    end
  end

  assign hit_o = event_hit(mode_i, prev_mode_q, level_i, prev_lvl_q);
endmodule

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
  import cmp_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we_i,
  input  logic      wr_flag_i,
  input  logic      wr_ie_i,
  input  logic      wr_cap_i,
  input  cmp_mode_e wr_mode_i,
  input  logic      ack_i,
  input  logic      hit_i,
  output logic      flag_o,
  output logic      ie_o,
  output logic      cap_o,
  output cmp_mode_e mode_o
);
  logic clr;
  assign clr = (we_i & wr_flag_i) | ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      ie_o   <= 1'b0;
      cap_o  <= 1'b0;
      mode_o <= MODE_TOGGLE;
    end else begin
      if (hit_i)    flag_o <= 1'b1;
      else if (clr) flag_o <= 1'b0;
      if (we_i) begin
        ie_o   <= wr_ie_i;
        cap_o  <= wr_cap_i;
        mode_o <= wr_mode_i;
      end
    end
  end
endmodule

// File: rtl/cmp_event_ctrl.sv
module cmp_event_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw_i,
  input  logic              glob_ie_i,
  input  logic              irq_ack_i,
  input  logic              reg_we_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              cap_trig_o
);
  localparam int USED_W = BIT_LVL + 1;

  logic      cmp_level;
  logic      evt_hit;
  logic      flag_q, ie_q, cap_q;
  cmp_mode_e mode_q;
  logic      unused_wdata;

  assign unused_wdata = ^reg_wdata_i[WORD_W-1:BIT_LVL];

  cmp_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .async_i(cmp_raw_i), .sync_o(cmp_level)
  );

  cmp_edge_det edge_i (
    .clk(clk), .rst_n(rst_n), .level_i(cmp_level),
    .mode_i(mode_q), .hit_o(evt_hit)
  );

  cmp_ctrl_regs regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i),
    .wr_flag_i(reg_wdata_i[BIT_FLAG]), .wr_ie_i(reg_wdata_i[BIT_IE]),
    .wr_cap_i(reg_wdata_i[BIT_CAP]), .wr_mode_i(cmp_mode_e'(reg_wdata_i[1:0])),
    .ack_i(irq_ack_i), .hit_i(evt_hit),
    .flag_o(flag_q), .ie_o(ie_q), .cap_o(cap_q), .mode_o(mode_q)
  );

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[BIT_LVL]  = cmp_level;
    reg_rdata_o[BIT_FLAG] = flag_q;
    reg_rdata_o[BIT_IE]   = ie_q;
    reg_rdata_o[BIT_CAP]  = cap_q;
    reg_rdata_o[1:0]      = mode_q;
  end

  assign irq_o      = flag_q & ie_q & glob_ie_i;
  assign cap_trig_o = cap_q & cmp_level;

  if (USED_W > WORD_W) begin : g_bad_width
    initial $error("WORD_W too small for the control/status word");
  end
endmodule

// File: rtl/cmp_event_chk.sv
module cmp_event_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_ie_i,
  input logic              irq_ack_i,
  input logic              reg_we_i,
  input logic [WORD_W-1:0] reg_wdata_i,
  input logic [WORD_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic              cap_trig_o,
  input logic              evt_hit
);
  // R5
  resv_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata_o[4]) |-> ($past(reg_rdata_o[1:0]) != 2'b01));

  // R6
  flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata_o[4]) |-> $past((reg_we_i & reg_wdata_i[4]) | irq_ack_i));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> reg_rdata_o[4]);

  // R9
  irq_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (glob_ie_i && reg_rdata_o[4] && reg_rdata_o[3]));

  // R10
  cap_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[2] |-> !cap_trig_o);

  // R10
  cap_follows_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_trig_o |-> reg_rdata_o[5]);

  // R13
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[WORD_W-1:6] == '0);
endmodule

bind cmp_event_ctrl cmp_event_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .glob_ie_i(glob_ie_i), .irq_ack_i(irq_ack_i),
  .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .irq_o(irq_o), .cap_trig_o(cap_trig_o), .evt_hit(evt_hit)
);

// File: tb/cmp_event_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmp_event_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0, gie = 1'b0, ack = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, cap;
  int         checks = 0, fails = 0;

  always #10 clk = ~clk;

  cmp_event_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .glob_ie_i(gie),
    .irq_ack_i(ack), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .cap_trig_o(cap)
  );

  // {mode[1:0], start level, end level, expected flag}
  localparam logic [4:0] VEC [9] = '{
    {2'b00, 1'b0, 1'b1, 1'b1}, {2'b00, 1'b1, 1'b0, 1'b1}, {2'b00, 1'b1, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1}, {2'b10, 1'b0, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b0, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b0}, {2'b01, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(4);
    // R11 reset state
    chk("R11 word", rdata, 8'h00);
    chk("R11 irq", {7'd0, irq}, 8'h00);
    chk("R11 cap", {7'd0, cap}, 8'h00);
    rst_n = 1'b1;
    cyc(2);
    chk("R11 after release", rdata, 8'h00);

    // R2 R3 R4 R5 vector table
    foreach (VEC[i]) begin
      logic [1:0] m;
      string tag;
      m = VEC[i][4:3];
      tag = (m == 2'b00) ? "R2" : (m == 2'b10) ? "R3" : (m == 2'b11) ? "R4" : "R5";
      raw = VEC[i][2]; cyc(4);
      wr({6'b000100, m}); cyc(3);
      wr({6'b000100, m} | 8'h10); cyc(3);
      chk({tag, " pre-clear"}, {7'd0, rdata[4]}, 8'h00);
      raw = VEC[i][1]; cyc(4);
      chk(tag, {7'd0, rdata[4]}, {7'd0, VEC[i][0]});
    end

    // R1 latency, mode 00, level currently 0
    wr(8'h00); raw = 1'b0; cyc(4); wr(8'h10); cyc(2);
    raw = 1'b1; cyc(1);
    chk("R1 one edge", {7'd0, rdata[5]}, 8'h00);
    cyc(1);
    chk("R1 two edges", {7'd0, rdata[5]}, 8'h01);
    cyc(2);

    // R6 write zero keeps flag, write one clears
    chk("R6 flag set", {7'd0, rdata[4]}, 8'h01);
    wr(8'h00); cyc(1);
    chk("R6 write zero", {7'd0, rdata[4]}, 8'h01);
    wr(8'h10); cyc(1);
    chk("R6 write one", {7'd0, rdata[4]}, 8'h00);

    // R7 acknowledge clears
    raw = 1'b0; cyc(4);
    chk("R7 flag set", {7'd0, rdata[4]}, 8'h01);
    ack = 1'b1; cyc(1); ack = 1'b0; cyc(1);
    chk("R7 ack", {7'd0, rdata[4]}, 8'h00);

    // R8 event and write-one clear collide: level changes at 2nd edge, hit next cycle
    raw = 1'b1; cyc(2);
    wr(8'h10);
    chk("R8 set wins", {7'd0, rdata[4]}, 8'h01);
    cyc(2);

    // R9 irq gating
    wr(8'h08); cyc(1);
    chk("R9 gie low", {7'd0, irq}, 8'h00);
    gie = 1'b1; cyc(1);
    chk("R9 all high", {7'd0, irq}, 8'h01);
    wr(8'h00); cyc(1);
    chk("R9 ie low", {7'd0, irq}, 8'h00);
    wr(8'h18); cyc(1);
    chk("R9 flag low", {7'd0, irq}, 8'h00);

    // R10 capture routing, level is 1
    chk("R10 off", {7'd0, cap}, 8'h00);
    wr(8'h04); cyc(1);
    chk("R10 on high", {7'd0, cap}, 8'h01);
    raw = 1'b0; cyc(3);
    chk("R10 on low", {7'd0, cap}, 8'h00);
    raw = 1'b1; cyc(3);
    chk("R10 on high again", {7'd0, cap}, 8'h01);
    wr(8'h00); cyc(1);
    chk("R10 off again", {7'd0, cap}, 8'h00);

    // R12 hazard 00 -> 11 with level high, interrupt enabled
    wr(8'h10); cyc(2);
    wr(8'h0B); cyc(2);
    chk("R12 toggle to rise", {7'd0, rdata[4]}, 8'h01);
    chk("R12 irq", {7'd0, irq}, 8'h01);
    // R12 hazard 11 -> 10 with level low
    raw = 1'b0; cyc(4);
    wr(8'h1B); cyc(2);
    chk("R12 clear", {7'd0, rdata[4]}, 8'h00);
    wr(8'h0A); cyc(2);
    chk("R12 rise to fall", {7'd0, rdata[4]}, 8'h01);

    // R13 reserved bits and read-only level
    wr(8'hFF); cyc(1);
    chk("R13 word", rdata, 8'h0F);
    wr(8'h10); cyc(1);
    chk("R13 final", rdata, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule